// File: doc/BRIEF.md
# Two-Level Instruction Scheduler Queue

This block holds renamed instructions until their source operands are available and then hands them, one per cycle, to execution. Each instruction arrives with two source tags, a ready flag per source, a destination tag and an opaque payload. A single result tag may be broadcast per cycle to wake waiting consumers.

Instructions are sorted on arrival by how many operands are still outstanding. Those missing both operands are parked in a small first-in first-out parking store. The parking store holds plain storage and is not searched by tag. Only its head entry is examined each cycle. The examination uses two inputs: the current broadcast, and a per-tag ready record indexed by tag. Everything else goes straight into the issue window. The parking store feeds its head into the issue window as soon as one of the head's operands is known to be ready. Because nothing in the issue window ever waits on two operands, each issue-window slot carries one wakeup comparator. The select logic issues the oldest ready slot, using a wrap-aware age stamp assigned at dispatch.

Top module: `twolvl_sched`

## Requirements
- R1: After reset the block issues nothing (`issue_valid` low), and `disp_ready` is high for an instruction bound for the issue window.
- R2: An instruction accepted with both ready flags high is visible on `issue_valid`/`issue_pay` in the cycle after the accepting clock edge.
- R3: An instruction accepted with exactly one ready flag low enters the issue window and is not issued until its missing tag is broadcast. It is visible on the issue outputs in the cycle after the edge that carries the broadcast. A broadcast of any other tag has no effect on it.
- R4: An instruction accepted with both ready flags low is parked. A broadcast of one of its tags alone does not make it issue. It issues in the cycle after the edge carrying the broadcast of its second tag.
- R5: The parking-store head is woken by a broadcast tag, and also by a per-tag ready record. The record is set by every broadcast and cleared for the destination tag of every accepted instruction. As a result, a tag broadcast while its instruction sat behind the head is not lost.
- R6: At most one parked instruction moves to the issue window per edge. Moves happen in arrival order, and only when the issue window had a free slot before that edge.
- R7: At most one instruction issues per cycle. Among ready slots the one accepted earliest is chosen, whatever slot it occupies.
- R8: `disp_ready` is low when the target structure is full. For the parking store, full means `WB_DEPTH` entries. For the issue window, full means fewer free slots than one plus a move occurring in the same cycle. An instruction presented while `disp_ready` is low is ignored.
- R9: A broadcast on the same edge that an instruction is accepted into the issue window, or moved into it, counts as a wakeup for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | An instruction is presented |
| disp_ready | output | 1 | The presented instruction can be accepted this cycle |
| op_a_tag | input | TAG_W | First source tag |
| op_a_rdy | input | 1 | First source already available |
| op_b_tag | input | TAG_W | Second source tag |
| op_b_rdy | input | 1 | Second source already available |
| dst_tag | input | TAG_W | Destination tag, marked not-ready in the ready record on acceptance |
| disp_pay | input | PAY_W | Opaque instruction payload |
| wake_valid | input | 1 | A result tag is broadcast this cycle |
| wake_tag | input | TAG_W | Broadcast result tag |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_pay | output | PAY_W | Payload of the issuing instruction |

## Verification
Several internal faults show up at the issue outputs within a cycle or two of the broadcast that should have released an instruction:
- A lost ready bit in the ready record leaves a parked instruction stuck in the parking store forever. `issue_valid` then stays low where a payload was due.
- A slot comparator that matches the wrong tag releases an instruction a cycle early or never.

A wrong age order shows as the payloads of two instructions that became ready on the same edge leaving in swapped order. A broken full check shows up in two ways: an ignored instruction later appears on `issue_pay`, or an accepted one overwrites a live slot and its payload never emerges.

// File: rtl/tls_pkg.sv
package tls_pkg;

   typedef enum logic {
      DEST_IQ = 1'b0,
      DEST_WB = 1'b1
   } dest_e;

   // both operands outstanding -> park, otherwise straight to the issue window
   function automatic dest_e steer(input logic rdy_a, input logic rdy_b);
      return (!rdy_a && !rdy_b) ? DEST_WB : DEST_IQ;
   endfunction

endpackage

// File: rtl/tls_wait_buf.sv
module tls_wait_buf #(
   parameter int TAG_W = 6,
   parameter int PAY_W = 8,
   parameter int AGE_W = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] in_ta,
   input  logic [TAG_W-1:0] in_tb,
   input  logic [AGE_W-1:0] in_age,
   input  logic [PAY_W-1:0] in_pay,
   input  logic             dst_we,
   input  logic [TAG_W-1:0] dst_tag,
   input  logic             wake_v,
   input  logic [TAG_W-1:0] wake_t,
   input  logic             pop,
   output logic             full,
   output logic             head_elig,
   output logic [TAG_W-1:0] out_pend_tag,
   output logic             out_pend_rdy,
   output logic [AGE_W-1:0] out_age,
   output logic [PAY_W-1:0] out_pay
);
   localparam int PW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int NTAG = 1 << TAG_W;

   logic [TAG_W-1:0] ta_m  [DEPTH];
   logic [TAG_W-1:0] tb_m  [DEPTH];
   logic [AGE_W-1:0] age_m [DEPTH];
   logic [PAY_W-1:0] pay_m [DEPTH];
   logic [PW-1:0]    rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0]    cnt;
   logic [NTAG-1:0]  sb_q;
   logic [TAG_W-1:0] h_a, h_b;
   logic             r_a, r_b;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_mod
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         ta_m[wr_ptr]  <= in_ta;
         tb_m[wr_ptr]  <= in_tb;
         age_m[wr_ptr] <= in_age;
         pay_m[wr_ptr] <= in_pay;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: ;
         endcase
      end
   end

   // ready record: cleared on destination allocation, set by broadcast (broadcast wins)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_q <= '0;
      end else begin
         if (dst_we) sb_q[dst_tag] <= 1'b0;
         if (wake_v) sb_q[wake_t]  <= 1'b1;
      end
   end

   assign h_a          = ta_m[rd_ptr];
   assign h_b          = tb_m[rd_ptr];
   assign r_a          = sb_q[h_a] | (wake_v && (wake_t == h_a));
   assign r_b          = sb_q[h_b] | (wake_v && (wake_t == h_b));
   assign full         = (cnt == CW'(DEPTH));
   assign head_elig    = (cnt != '0) && (r_a || r_b);
   assign out_pend_rdy = r_a && r_b;
   assign out_pend_tag = r_a ? h_b : h_a;
   assign out_age      = age_m[rd_ptr];
   assign out_pay      = pay_m[rd_ptr];

   // R8
   wb_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R6
   wb_pop_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_elig);

endmodule

// File: rtl/tls_oldest_sel.sv
module tls_oldest_sel #(
   parameter int DEPTH = 4,
   parameter int AGE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DEPTH-1:0]            cand,
   input  logic [DEPTH-1:0][AGE_W-1:0] ages,
   output logic [DEPTH-1:0]            gnt,
   output logic                        any,
   output logic [$clog2(DEPTH)-1:0]    sel
);
   localparam int IW = $clog2(DEPTH);

   function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   logic [AGE_W-1:0] best_age;

   always_comb begin
      any      = 1'b0;
      sel      = '0;
      best_age = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!any || older(ages[i], best_age))) begin
            any      = 1'b1;
            sel      = IW'(i);
            best_age = ages[i];
         end
      end
      gnt = '0;
      if (any) gnt[sel] = 1'b1;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_chk
         // R7
         sel_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (any && cand[i]) |-> !older(ages[i], ages[sel]));
      end
   endgenerate

endmodule

// File: rtl/tls_issue_q.sv
module tls_issue_q #(
   parameter int TAG_W = 6,
   parameter int PAY_W = 8,
   parameter int AGE_W = 8,
   parameter int DEPTH = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        xa_en,
   input  logic [TAG_W-1:0]            xa_tag,
   input  logic                        xa_rdy,
   input  logic [AGE_W-1:0]            xa_age,
   input  logic [PAY_W-1:0]            xa_pay,
   input  logic                        da_en,
   input  logic [TAG_W-1:0]            da_tag,
   input  logic                        da_rdy,
   input  logic [AGE_W-1:0]            da_age,
   input  logic [PAY_W-1:0]            da_pay,
   input  logic                        wake_v,
   input  logic [TAG_W-1:0]            wake_t,
   input  logic [DEPTH-1:0]            gnt,
   output logic [DEPTH-1:0]            ent_ok,
   output logic [DEPTH-1:0][AGE_W-1:0] ent_age,
   output logic [DEPTH-1:0][PAY_W-1:0] ent_pay,
   output logic [$clog2(DEPTH+1)-1:0]  free_cnt
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DEPTH-1:0]            vld_q, rdy_q;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [IW-1:0]               f1_idx, f2_idx, d_idx;
   logic                        f1_hit, f2_hit;

   // first two free slots: the move port takes the first, dispatch the next one
   always_comb begin
      f1_hit   = 1'b0;
      f2_hit   = 1'b0;
      f1_idx   = '0;
      f2_idx   = '0;
      free_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld_q[i]) begin
            free_cnt = free_cnt + CW'(1);
            if (!f1_hit) begin
               f1_hit = 1'b1;
               f1_idx = IW'(i);
            end else if (!f2_hit) begin
               f2_hit = 1'b1;
               f2_idx = IW'(i);
            end
         end
      end
   end

   assign d_idx = xa_en ? f2_idx : f1_idx;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic hit;
         logic wr_x, wr_d;
         // the single comparator of this slot
         assign hit  = wake_v && (wake_t == tag_q[i]);
         assign wr_x = xa_en && (f1_idx == IW'(i));
         assign wr_d = da_en && (d_idx == IW'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[i] <= 1'b0;
               rdy_q[i] <= 1'b0;
            end else if (wr_x) begin
               vld_q[i] <= 1'b1;
               rdy_q[i] <= xa_rdy;
            end else if (wr_d) begin
               vld_q[i] <= 1'b1;
               rdy_q[i] <= da_rdy;
            end else if (gnt[i]) begin
               vld_q[i] <= 1'b0;
            end else if (vld_q[i] && hit) begin
               rdy_q[i] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_x) begin
               tag_q[i]   <= xa_tag;
               ent_age[i] <= xa_age;
               ent_pay[i] <= xa_pay;
            end else if (wr_d) begin
               tag_q[i]   <= da_tag;
               ent_age[i] <= da_age;
               ent_pay[i] <= da_pay;
            end
         end

         assign ent_ok[i] = vld_q[i] && rdy_q[i];

         // R3
         iq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[i] && !rdy_q[i] && hit) |=> rdy_q[i]);
      end
   endgenerate

   // R6
   iq_move_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xa_en |-> (free_cnt != '0));

   // R8
   iq_dual_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xa_en && da_en) |-> (free_cnt >= CW'(2)));

endmodule

// File: rtl/twolvl_sched.sv
module twolvl_sched #(
   parameter int TAG_W    = 6,
   parameter int PAY_W    = 8,
   parameter int IQ_DEPTH = 4,
   parameter int WB_DEPTH = 4,
   parameter int AGE_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   output logic             disp_ready,
   input  logic [TAG_W-1:0] op_a_tag,
   input  logic             op_a_rdy,
   input  logic [TAG_W-1:0] op_b_tag,
   input  logic             op_b_rdy,
   input  logic [TAG_W-1:0] dst_tag,
   input  logic [PAY_W-1:0] disp_pay,
   input  logic             wake_valid,
   input  logic [TAG_W-1:0] wake_tag,
   output logic             issue_valid,
   output logic [PAY_W-1:0] issue_pay
);
   import tls_pkg::*;

   localparam int QCW = $clog2(IQ_DEPTH + 1);
   localparam int QIW = $clog2(IQ_DEPTH);

   generate
      if (IQ_DEPTH < 2) begin : g_bad_iq
         $error("IQ_DEPTH must be at least 2");
      end
      if (WB_DEPTH < 2) begin : g_bad_wb
         $error("WB_DEPTH must be at least 2");
      end
      if (AGE_W < $clog2(IQ_DEPTH + WB_DEPTH) + 2) begin : g_bad_age
         $error("AGE_W too narrow for the in-flight window");
      end
   endgenerate

   dest_e                          dest;
   logic                           fire, wb_push, iq_push, xfer;
   logic                           wb_full, head_elig, head_rdy;
   logic [TAG_W-1:0]               head_tag, pend_tag;
   logic [AGE_W-1:0]               head_age, age_q;
   logic [PAY_W-1:0]               head_pay;
   logic                           d_rdy;
   logic [QCW-1:0]                 iq_free, iq_need;
   logic [IQ_DEPTH-1:0]            ok, gnt;
   logic [IQ_DEPTH-1:0][AGE_W-1:0] ages;
   logic [IQ_DEPTH-1:0][PAY_W-1:0] pays;
   logic [QIW-1:0]                 sel;

   assign dest       = steer(op_a_rdy, op_b_rdy);
   assign xfer       = head_elig && (iq_free != '0);
   assign iq_need    = xfer ? QCW'(2) : QCW'(1);
   assign disp_ready = (dest == DEST_WB) ? !wb_full : (iq_free >= iq_need);
   assign fire       = disp_valid && disp_ready;
   assign wb_push    = fire && (dest == DEST_WB);
   assign iq_push    = fire && (dest == DEST_IQ);
   assign pend_tag   = op_a_rdy ? op_b_tag : op_a_tag;
   assign d_rdy      = (op_a_rdy && op_b_rdy) || (wake_valid && (wake_tag == pend_tag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    age_q <= '0;
      else if (fire) age_q <= age_q + 1'b1;
   end

   tls_wait_buf #(.TAG_W(TAG_W), .PAY_W(PAY_W), .AGE_W(AGE_W), .DEPTH(WB_DEPTH)) u_wb (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (wb_push),
      .in_ta        (op_a_tag),
      .in_tb        (op_b_tag),
      .in_age       (age_q),
      .in_pay       (disp_pay),
      .dst_we       (fire),
      .dst_tag      (dst_tag),
      .wake_v       (wake_valid),
      .wake_t       (wake_tag),
      .pop          (xfer),
      .full         (wb_full),
      .head_elig    (head_elig),
      .out_pend_tag (head_tag),
      .out_pend_rdy (head_rdy),
      .out_age      (head_age),
      .out_pay      (head_pay)
   );

   tls_issue_q #(.TAG_W(TAG_W), .PAY_W(PAY_W), .AGE_W(AGE_W), .DEPTH(IQ_DEPTH)) u_iq (
      .clk      (clk),
      .rst_n    (rst_n),
      .xa_en    (xfer),
      .xa_tag   (head_tag),
      .xa_rdy   (head_rdy),
      .xa_age   (head_age),
      .xa_pay   (head_pay),
      .da_en    (iq_push),
      .da_tag   (pend_tag),
      .da_rdy   (d_rdy),
      .da_age   (age_q),
      .da_pay   (disp_pay),
      .wake_v   (wake_valid),
      .wake_t   (wake_tag),
      .gnt      (gnt),
      .ent_ok   (ok),
      .ent_age  (ages),
      .ent_pay  (pays),
      .free_cnt (iq_free)
   );

   tls_oldest_sel #(.DEPTH(IQ_DEPTH), .AGE_W(AGE_W)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (ok),
      .ages  (ages),
      .gnt   (gnt),
      .any   (issue_valid),
      .sel   (sel)
   );

   assign issue_pay = pays[sel];

endmodule

// File: tb/sim_twolvl_sched.sv
module sim_twolvl_sched;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       disp_valid, disp_ready;
   logic [5:0] op_a_tag, op_b_tag, dst_tag, wake_tag;
   logic       op_a_rdy, op_b_rdy, wake_valid;
   logic [7:0] disp_pay, issue_pay;
   logic       issue_valid;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   twolvl_sched u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .disp_valid  (disp_valid),
      .disp_ready  (disp_ready),
      .op_a_tag    (op_a_tag),
      .op_a_rdy    (op_a_rdy),
      .op_b_tag    (op_b_tag),
      .op_b_rdy    (op_b_rdy),
      .dst_tag     (dst_tag),
      .disp_pay    (disp_pay),
      .wake_valid  (wake_valid),
      .wake_tag    (wake_tag),
      .issue_valid (issue_valid),
      .issue_pay   (issue_pay)
   );

   typedef struct packed {
      logic       ra;
      logic       rb;
      logic [5:0] ta;
      logic [5:0] tb;
      logic [7:0] pay;
      logic       wv;
      logic [5:0] wt;
      logic       e1;
      logic       e2;
   } vec_t;

   // dispatch, then one broadcast, then expect issue after dispatch (e1) or after broadcast (e2)
   localparam vec_t VT [6] = '{
      '{1'b1, 1'b1, 6'd1, 6'd2, 8'h11, 1'b0, 6'd0, 1'b1, 1'b0},
      '{1'b0, 1'b1, 6'd3, 6'd9, 8'h22, 1'b1, 6'd3, 1'b0, 1'b1},
      '{1'b1, 1'b0, 6'd9, 6'd4, 8'h33, 1'b1, 6'd4, 1'b0, 1'b1},
      '{1'b1, 1'b1, 6'd8, 6'd8, 8'h44, 1'b1, 6'd5, 1'b1, 1'b0},
      '{1'b0, 1'b1, 6'd6, 6'd2, 8'h55, 1'b1, 6'd6, 1'b0, 1'b1},
      '{1'b1, 1'b0, 6'd1, 6'd7, 8'h66, 1'b1, 6'd7, 1'b0, 1'b1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic dv, input logic ra, input logic rb,
                        input logic [5:0] ta, input logic [5:0] tb, input logic [5:0] dt,
                        input logic [7:0] pay, input logic wv, input logic [5:0] wt);
      disp_valid = dv;
      op_a_rdy   = ra;
      op_b_rdy   = rb;
      op_a_tag   = ta;
      op_b_tag   = tb;
      dst_tag    = dt;
      disp_pay   = pay;
      wake_valid = wv;
      wake_tag   = wt;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic step(input logic dv, input logic ra, input logic rb,
                       input logic [5:0] ta, input logic [5:0] tb, input logic [5:0] dt,
                       input logic [7:0] pay, input logic wv, input logic [5:0] wt);
      drive(dv, ra, rb, ta, tb, dt, pay, wv, wt);
      cyc();
   endtask

   task automatic idle();
      step(1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd63, 8'h00, 1'b0, 6'd0);
   endtask

   task automatic wake(input logic [5:0] t);
      step(1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd63, 8'h00, 1'b1, t);
   endtask

   task automatic do_reset();
      drive(1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd63, 8'h00, 1'b0, 6'd0);
      rst_n = 1'b0;
      cyc();
      cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic iss(input string req, input logic [7:0] pay);
      chk(req, int'(issue_valid), 1);
      chk(req, int'(issue_pay), int'(pay));
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1
      chk("R1 issue_valid after reset", int'(issue_valid), 0);
      chk("R1 disp_ready after reset", int'(disp_ready), 1);

      // R2 R3: table walk
      for (int i = 0; i < 6; i++) begin
         step(1'b1, VT[i].ra, VT[i].rb, VT[i].ta, VT[i].tb, 6'(50 + i), VT[i].pay, 1'b0, 6'd0);
         chk("R2 issue after dispatch", int'(issue_valid), int'(VT[i].e1));
         if (VT[i].e1) chk("R2 payload", int'(issue_pay), int'(VT[i].pay));
         step(1'b0, 1'b1, 1'b1, 6'd0, 6'd0, 6'd63, 8'h00, VT[i].wv, VT[i].wt);
         chk("R3 issue after broadcast", int'(issue_valid), int'(VT[i].e2));
         if (VT[i].e2) chk("R3 payload", int'(issue_pay), int'(VT[i].pay));
         idle();
         chk("R3 window drained", int'(issue_valid), 0);
      end

      // R9 same-edge broadcast at dispatch
      step(1'b1, 1'b0, 1'b1, 6'd25, 6'd0, 6'd61, 8'h77, 1'b1, 6'd25);
      iss("R9 same-edge wake", 8'h77);
      idle();
      chk("R9 drained", int'(issue_valid), 0);

      // R4 parked path
      do_reset();
      step(1'b1, 1'b0, 1'b0, 6'd10, 6'd11, 6'd62, 8'hA1, 1'b0, 6'd0);
      chk("R4 parked not issued", int'(issue_valid), 0);
      wake(6'd10);
      chk("R4 one wake not enough", int'(issue_valid), 0);
      wake(6'd11);
      iss("R4 issue after second wake", 8'hA1);
      idle();
      chk("R4 drained", int'(issue_valid), 0);

      // R5 wake for an entry behind the head
      do_reset();
      step(1'b1, 1'b0, 1'b0, 6'd12, 6'd13, 6'd62, 8'hB1, 1'b0, 6'd0);
      step(1'b1, 1'b0, 1'b0, 6'd14, 6'd15, 6'd63, 8'hB2, 1'b0, 6'd0);
      wake(6'd14);
      chk("R5 unrelated head stays", int'(issue_valid), 0);
      wake(6'd12);
      chk("R5 no issue yet", int'(issue_valid), 0);
      idle();
      chk("R5 no issue after second move", int'(issue_valid), 0);
      wake(6'd13);
      iss("R5 first parked issues", 8'hB1);
      wake(6'd15);
      iss("R5 remembered wake kept", 8'hB2);
      idle();
      chk("R5 drained", int'(issue_valid), 0);

      // R7 oldest wins over lower slot
      do_reset();
      step(1'b1, 1'b1, 1'b1, 6'd0, 6'd0, 6'd61, 8'hD0, 1'b0, 6'd0);
      iss("R7 filler", 8'hD0);
      step(1'b1, 1'b0, 1'b1, 6'd30, 6'd0, 6'd61, 8'hD1, 1'b0, 6'd0);
      chk("R7 old waits", int'(issue_valid), 0);
      step(1'b1, 1'b1, 1'b1, 6'd0, 6'd0, 6'd61, 8'hD2, 1'b1, 6'd30);
      iss("R7 oldest first", 8'hD1);
      idle();
      iss("R7 younger next", 8'hD2);
      idle();
      chk("R7 drained", int'(issue_valid), 0);

      // R8 R6: full issue window, parked move waits for room
      do_reset();
      for (int i = 0; i < 4; i++)
         step(1'b1, 1'b0, 1'b1, 6'(33 + i), 6'd0, 6'd61, 8'(8'hE1 + i), 1'b0, 6'd0);
      drive(1'b1, 1'b0, 1'b1, 6'd37, 6'd0, 6'd61, 8'hE5, 1'b0, 6'd0);
      #1;
      chk("R8 window full stalls", int'(disp_ready), 0);
      cyc();
      step(1'b1, 1'b0, 1'b0, 6'd52, 6'd53, 6'd61, 8'hE9, 1'b0, 6'd0);
      wake(6'd52);
      chk("R6 no move into full window", int'(issue_valid), 0);
      wake(6'd33);
      iss("R8 drain 1", 8'hE1);
      wake(6'd34);
      iss("R8 drain 2", 8'hE2);
      wake(6'd35);
      iss("R8 drain 3", 8'hE3);
      wake(6'd36);
      iss("R8 drain 4", 8'hE4);
      wake(6'd53);
      iss("R6 moved after room", 8'hE9);
      wake(6'd37);
      chk("R8 stalled instruction ignored", int'(issue_valid), 0);

      // R8 R6: full parking store, arrival order
      do_reset();
      for (int i = 0; i < 4; i++)
         step(1'b1, 1'b0, 1'b0, 6'(40 + 2 * i), 6'(41 + 2 * i), 6'd60, 8'(8'hF1 + i), 1'b0, 6'd0);
      drive(1'b1, 1'b0, 1'b0, 6'd48, 6'd49, 6'd60, 8'hF5, 1'b0, 6'd0);
      #1;
      chk("R8 parking full stalls", int'(disp_ready), 0);
      cyc();
      wake(6'd42);
      chk("R6 second entry cannot pass head", int'(issue_valid), 0);
      wake(6'd40);
      chk("R6 head moved not issued", int'(issue_valid), 0);
      idle();
      wake(6'd41);
      iss("R6 first in order", 8'hF1);
      wake(6'd43);
      iss("R6 second in order", 8'hF2);
      idle();
      chk("R6 rest still parked", int'(issue_valid), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule